// File: doc/BRIEF.md
# Single-to-Half Float Narrowing Converter

This block narrows a 32-bit IEEE 754 single-precision operand to a 16-bit half-precision value. It is meant for the result stage of a floating-point unit. It handles all input classes: NaN, infinity, zero, normal values, single-precision subnormals, results that overflow the half range, and results that fall into the half subnormal range. It rounds correctly under five rounding modes and reports the accrued exception flags.

The 16-bit result sits in the low bits of a register-wide word of `FLEN` bits, and every bit above it is set to one. An operand presented with `in_valid` produces its result one clock later. A rounding-mode code of 7 takes the mode from `dyn_rm` instead of `in_rm`. If the mode that results is not a legal one, the block raises `out_illegal` and produces no result.

Top module: `sp2hp_narrow`

## Requirements
- R1: An operand with exponent 8'hFF and a nonzero fraction gives 16'h7E00 whatever its sign. Flag bit 4 (invalid) is set only when fraction bit 22 is 0, which marks a signalling NaN. A quiet NaN sets no flag.
- R2: An operand with exponent 8'hFF and a zero fraction gives an infinity that keeps the operand's sign: 16'h7C00 or 16'hFC00. No flags are set.
- R3: An operand whose magnitude is zero gives a zero that keeps the operand's sign, with no flags set.
- R4: Bits FLEN-1 down to 16 of `out_res` are all ones whenever `out_valid` is high.
- R5: A normal operand whose value fits exactly in half precision has its exponent rebiased from 127 to 15 and its fraction truncated to the top 10 bits. No flags are set.
- R6: Rounding mode codes are 0 = to nearest with ties to even, 1 = toward zero, 2 = toward minus infinity, 3 = toward plus infinity, 4 = to nearest with ties away from zero. Flag bit 0 (inexact) is set whenever discarded bits are nonzero.
- R7: The low 9 fraction bits of the operand act only as a sticky bit below the round position. A nonzero value there breaks a tie upward under mode 0.
- R8: A rounded magnitude at or above 2^16 gives overflow and sets flag bits 2 and 0. The result is infinity under modes 0 and 4, under mode 3 for a positive operand and under mode 2 for a negative one. Otherwise the result is 16'h7BFF with the operand's sign.
- R9: A result below 2^-14 is denormalised before it is rounded. Flag bit 1 (underflow) is set when the result is both tiny and inexact. Tininess is judged after rounding to 11 significant bits with an unbounded exponent. Flag bit 3 is always 0.
- R10: Mode code 7 selects the mode held in `dyn_rm`. If the mode that results is 5, 6 or 7, `out_illegal` pulses high one cycle later and `out_valid` stays low.
- R11: `out_valid` goes high exactly one cycle after an accepted operand and stays low otherwise. The reset state has both output strobes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| in_op | input | 32 | Single-precision operand |
| in_rm | input | 3 | Rounding-mode code from the operation |
| dyn_rm | input | 3 | Mode used when `in_rm` is 7 |
| out_valid | output | 1 | Result strobe |
| out_res | output | FLEN | Boxed half-precision result |
| out_flags | output | 5 | {invalid, divide-by-zero, overflow, underflow, inexact} |
| out_illegal | output | 1 | Illegal-mode strobe |

## Verification
The block keeps no state across operations apart from its output register. Any error therefore shows up on the result or flags of the same operation, exactly one cycle after it is presented. Errors in the rounding path are most likely at three places: the round bit, the sticky bit, and the carry out of the fraction into the exponent. The stimulus therefore aims at ties, sticky-broken ties, rounding that carries into overflow, and rounding that carries out of the subnormal range. A wrong mode selection shows up as a wrong result, or as a missing or extra illegal strobe, in the cycle after that operand.

// File: rtl/sp2hp_narrow.sv
module sp2hp_narrow #(
  parameter int FLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [31:0]     in_op,
  input  logic [2:0]      in_rm,
  input  logic [2:0]      dyn_rm,
  output logic            out_valid,
  output logic [FLEN-1:0] out_res,
  output logic [4:0]      out_flags,
  output logic            out_illegal
);
  localparam int BOXW = FLEN - 16;

  function automatic logic rnd_up(input logic [2:0] md, input logic s, input logic lsb,
                                  input logic r, input logic st);
    case (md)
      3'd0:    rnd_up = r & (st | lsb);
      3'd2:    rnd_up = (r | st) & s;
      3'd3:    rnd_up = (r | st) & ~s;
      3'd4:    rnd_up = r;
      default: rnd_up = 1'b0;
    endcase
  endfunction

  logic        sgn;
  logic [7:0]  e8;
  logic [22:0] f23;
  assign sgn = in_op[31];
  assign e8  = in_op[30:23];
  assign f23 = in_op[22:0];

  logic [2:0] mode;
  logic       bad_mode;
  assign mode     = (in_rm == 3'd7) ? dyn_rm : in_rm;
  assign bad_mode = mode > 3'd4;

  logic [14:0] m15;
  assign m15 = {1'b1, f23[22:10], f23[9] | (|f23[8:0])};

  logic signed [9:0] he, sh_raw;
  logic [4:0]  sh;
  assign he     = $signed({2'b00, e8}) - 10'sd112;
  assign sh_raw = 10'sd1 - he;
  assign sh     = (he > 0) ? 5'd0 : ((sh_raw > 10'sd16) ? 5'd16 : sh_raw[4:0]);

  logic [30:0] wide;
  logic [14:0] shf;
  logic [10:0] keep;
  logic        rb, st, inx, up, up_u, tiny, ovf, to_inf;
  logic [15:0] sum16;
  logic [4:0]  expf;

  assign wide  = {m15, 16'b0} >> sh;
  assign shf   = wide[30:16];
  assign keep  = shf[14:4];
  assign rb    = shf[3];
  assign st    = (|shf[2:0]) | (|wide[15:0]);
  assign inx   = rb | st;
  assign up    = rnd_up(mode, sgn, keep[0], rb, st);
  assign expf  = (he > 0) ? he[4:0] : 5'd0;
  assign sum16 = {1'b0, expf, keep[9:0]} + {15'b0, up};
  assign ovf   = (he > 10'sd30) || (sum16[14:10] == 5'h1F);
  assign to_inf = (mode == 3'd0) || (mode == 3'd4) || (mode == 3'd3 && !sgn) || (mode == 3'd2 && sgn);

  assign up_u = rnd_up(mode, sgn, m15[4], m15[3], |m15[2:0]);
  assign tiny = (he < 0) || (he == 0 && !((&m15[14:4]) && up_u));

  logic [15:0] res_c;
  logic [4:0]  flg_c;

  always_comb begin
    if (e8 == 8'hFF && f23 != 23'd0) begin
      res_c = 16'h7E00;
      flg_c = {~f23[22], 4'b0};
    end else if (e8 == 8'hFF) begin
      res_c = {sgn, 15'h7C00};
      flg_c = 5'b0;
    end else if (e8 == 8'h00 && f23 == 23'd0) begin
      res_c = {sgn, 15'h0};
      flg_c = 5'b0;
    end else if (ovf) begin
      res_c = {sgn, to_inf ? 15'h7C00 : 15'h7BFF};
      flg_c = 5'b00101;
    end else begin
      res_c = {sgn, sum16[14:0]};
      flg_c = {3'b000, tiny & inx, inx};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      out_res     <= '0;
      out_flags   <= '0;
    end else begin
      out_valid   <= in_valid & ~bad_mode;
      out_illegal <= in_valid & bad_mode;
      if (in_valid && !bad_mode) begin
        out_res   <= {{BOXW{1'b1}}, res_c};
        out_flags <= flg_c;
      end
    end
  end

  // R11
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !bad_mode) |=> out_valid);
  // R10
  illegal_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_illegal));
  // R10
  illegal_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && bad_mode) |=> (out_illegal && !out_valid));
  // R4
  box_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (&out_res[FLEN-1:16]));
  // R1
  nv_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_flags[4]) |-> (out_res[15:0] == 16'h7E00));
  // R8
  of_nx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_flags[2]) |-> out_flags[0]);
  // R9
  uf_nx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_flags[1]) |-> (out_flags[0] && !out_flags[3]));
endmodule

// File: tb/sp2hp_narrow_tb.sv
module sp2hp_narrow_tb;
  localparam int FLEN = 64;
  localparam time PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [31:0] in_op = '0;
  logic [2:0] in_rm = '0, dyn_rm = '0;
  logic out_valid, out_illegal;
  logic [FLEN-1:0] out_res;
  logic [4:0] out_flags;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  typedef struct {
    logic        ill;
    logic [15:0] res;
    logic [4:0]  flg;
    string       tag;
  } item_t;
  item_t sb[$];

  always #(PERIOD/2) clk = ~clk;

  sp2hp_narrow #(.FLEN(FLEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_rm(in_rm), .dyn_rm(dyn_rm), .out_valid(out_valid), .out_res(out_res),
    .out_flags(out_flags), .out_illegal(out_illegal)
  );

  task automatic send(input logic [31:0] op, input logic [2:0] rm, input logic [2:0] dr,
                      input logic [15:0] r, input logic [4:0] f, input logic ill, input string tag);
    item_t it;
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_rm = rm; dyn_rm = dr;
    it.ill = ill; it.res = r; it.flg = f; it.tag = tag;
    sb.push_back(it);
  endtask

  always @(negedge clk) begin
    if (rst_n && (out_valid || out_illegal)) begin
      item_t e;
      logic [FLEN-1:0] want;
      checks++;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL R11 unexpected output: valid=%b illegal=%b expected none", out_valid, out_illegal);
      end else begin
        e = sb.pop_front();
        want = {{(FLEN-16){1'b1}}, e.res};
        if (e.ill) begin
          if (!(out_illegal && !out_valid)) begin
            fails++;
            $display("FAIL %s illegal=%b valid=%b expected illegal=1 valid=0", e.tag, out_illegal, out_valid);
          end
        end else if (!out_valid || out_illegal || out_res !== want || out_flags !== e.flg) begin
          fails++;
          $display("FAIL %s res=%h flags=%b valid=%b expected res=%h flags=%b valid=1",
                   e.tag, out_res, out_flags, out_valid, want, e.flg);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD*20000);
    checks++; fails++;
    $display("FAIL watchdog expired: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_illegal !== 1'b0) begin
      fails++;
      $display("FAIL R11 reset: valid=%b illegal=%b expected 0 0", out_valid, out_illegal);
    end
    rst_n = 1'b1;
    // R1 NaN handling
    send(32'h7FC00000, 0, 0, 16'h7E00, 5'h00, 0, "R1 qnan");
    send(32'hFF800001, 0, 0, 16'h7E00, 5'h10, 0, "R1 snan");
    // R2 infinities
    send(32'h7F800000, 1, 0, 16'h7C00, 5'h00, 0, "R2 +inf");
    send(32'hFF800000, 0, 0, 16'hFC00, 5'h00, 0, "R2 -inf");
    // R3 zeros
    send(32'h80000000, 3, 0, 16'h8000, 5'h00, 0, "R3 -zero");
    send(32'h00000000, 2, 0, 16'h0000, 5'h00, 0, "R3 +zero");
    // R5 exact normals, R4 boxing checked on every result
    send(32'h3F800000, 0, 0, 16'h3C00, 5'h00, 0, "R5 one R4");
    send(32'hC0000000, 0, 0, 16'hC000, 5'h00, 0, "R5 minus two");
    send(32'h477FE000, 0, 0, 16'h7BFF, 5'h00, 0, "R5 max finite");
    // R6 tie 1+2^-11 under each mode
    send(32'h3F801000, 0, 0, 16'h3C00, 5'h01, 0, "R6 tie rne");
    send(32'h3F801000, 1, 0, 16'h3C00, 5'h01, 0, "R6 tie rtz");
    send(32'h3F801000, 3, 0, 16'h3C01, 5'h01, 0, "R6 tie rup");
    send(32'h3F801000, 4, 0, 16'h3C01, 5'h01, 0, "R6 tie rmm");
    send(32'hBF801000, 2, 0, 16'hBC01, 5'h01, 0, "R6 neg tie rdn");
    send(32'hBF801000, 3, 0, 16'hBC00, 5'h01, 0, "R6 neg tie rup");
    // R7 sticky from the lowest fraction bits
    send(32'h3F801001, 0, 0, 16'h3C01, 5'h01, 0, "R7 sticky breaks tie");
    send(32'h3F800001, 3, 0, 16'h3C01, 5'h01, 0, "R7 sticky only rup");
    send(32'h3F800001, 0, 0, 16'h3C00, 5'h01, 0, "R7 sticky only rne");
    // R8 overflow
    send(32'h4788B800, 0, 0, 16'h7C00, 5'h05, 0, "R8 ovf rne");
    send(32'h4788B800, 1, 0, 16'h7BFF, 5'h05, 0, "R8 ovf rtz");
    send(32'h4788B800, 2, 0, 16'h7BFF, 5'h05, 0, "R8 ovf rdn pos");
    send(32'hC788B800, 2, 0, 16'hFC00, 5'h05, 0, "R8 ovf rdn neg");
    send(32'hC788B800, 3, 0, 16'hFBFF, 5'h05, 0, "R8 ovf rup neg");
    send(32'h477FF000, 0, 0, 16'h7C00, 5'h05, 0, "R8 round into ovf");
    send(32'h477FF000, 1, 0, 16'h7BFF, 5'h01, 0, "R8 no ovf rtz");
    // R9 subnormal and tininess after rounding
    send(32'h33800000, 0, 0, 16'h0001, 5'h00, 0, "R9 exact min sub");
    send(32'h33000000, 0, 0, 16'h0000, 5'h03, 0, "R9 half min rne");
    send(32'h33000000, 3, 0, 16'h0001, 5'h03, 0, "R9 half min rup");
    send(32'h387FFFFF, 0, 0, 16'h0400, 5'h01, 0, "R9 rounds to normal");
    send(32'h387FFFFF, 1, 0, 16'h03FF, 5'h03, 0, "R9 tiny rtz");
    send(32'h00000001, 0, 0, 16'h0000, 5'h03, 0, "R9 single sub rne");
    send(32'h80000001, 2, 0, 16'h8001, 5'h03, 0, "R9 single sub rdn");
    // R10 dynamic and illegal modes
    send(32'h3F801001, 7, 1, 16'h3C00, 5'h01, 0, "R10 dyn rtz");
    send(32'h3F801000, 7, 4, 16'h3C01, 5'h01, 0, "R10 dyn rmm");
    send(32'h3F800000, 5, 0, 16'h0000, 5'h00, 1, "R10 rm5");
    send(32'h3F800000, 6, 0, 16'h0000, 5'h00, 1, "R10 rm6");
    send(32'h3F800000, 7, 6, 16'h0000, 5'h00, 1, "R10 dyn 6");
    send(32'h3F800000, 7, 7, 16'h0000, 5'h00, 1, "R10 dyn 7");
    send(32'h40000000, 0, 0, 16'h4000, 5'h00, 0, "R11 after illegal");
    @(negedge clk);
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R11 missing outputs: pending=%0d expected 0", sb.size());
    end
    finish_run();
  end
endmodule